// File: doc/BRIEF.md
# Condition Code Evaluator

This block turns a 4-bit condition selector and the five processor status flags (overflow, carry, zero, sign, saturation) into one "condition holds" bit. It has no clock and no state. The same bit drives two consumers that sit next to each other in an execute stage.

The first consumer is the short conditional branch. When the condition holds, the block adds a sign-extended 9-bit displacement to the current PC. When it does not hold, the PC moves on by one 2-byte instruction. The second consumer is a "set on condition" result. It is a 32-bit word that holds exactly 0 or 1 and goes to a destination register.

Fetch, decode and the register file sit outside the block. They supply the selector, the flags, the PC and the displacement, and they take the results.

Top module: `cond_unit`

## Requirements
- R1: Selector codes 0, 1, 2, 3 and 4 evaluate true exactly when overflow, carry, zero, (carry OR zero) and sign, respectively, equal 1.
- R2: Selector code 5 always evaluates true, whatever the flags are.
- R3: Code 6 evaluates (sign XOR overflow), the signed less-than test. Code 7 evaluates ((sign XOR overflow) OR zero), the signed less-or-equal test.
- R4: For every low code k in {0,1,2,3,4,6,7}, code k+8 evaluates to the logical inverse of code k for the same flags.
- R5: Code 13 (hex D) evaluates true exactly when the saturation flag is 1.
- R6: When the condition holds, `next_pc` equals `cur_pc` plus the 9-bit displacement sign-extended to 32 bits, with modulo-2^32 wrap.
- R7: When the condition does not hold, `next_pc` equals `cur_pc` + 2, with modulo-2^32 wrap.
- R8: `flag_word` is the 32-bit value 1 when the condition holds and 0 otherwise. Bits 31..1 are always 0.
- R9: Displacement bit 8 is the sign bit. A displacement of 0x100 is -256 and 0x0FF is +255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cc_sel | input | 4 | Condition selector, 0..15 |
| flag_ov | input | 1 | Overflow flag |
| flag_cy | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_sat | input | 1 | Saturation flag |
| cur_pc | input | 32 | Address of the branch instruction |
| disp | input | 9 | Branch displacement, two's complement |
| cond_true | output | 1 | Selected condition holds |
| next_pc | output | 32 | Address of the next instruction to fetch |
| flag_word | output | 32 | Set-on-condition result, 0 or 1 |

## Verification
The hardest cases to reach are the flag combinations that real arithmetic seldom produces together. Examples are zero set while sign and overflow disagree, or saturation set while every other flag is clear. These are exactly the combinations on which the signed-compare and saturation codes differ from their neighbours. The stimulus therefore sweeps every selector against all 32 flag patterns directly, so no arithmetic history is needed to reach them. Random PC and displacement values then cover the adder. Directed cases add the extreme displacements and PC wrap-around in both directions.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  typedef struct packed {
    logic ov;
    logic cy;
    logic z;
    logic s;
    logic sat;
  } psw_flags_t;

  typedef enum logic [3:0] {
    CC_OVF    = 4'h0,
    CC_CARRY  = 4'h1,
    CC_ZERO   = 4'h2,
    CC_LEU    = 4'h3,
    CC_NEG    = 4'h4,
    CC_ALWAYS = 4'h5,
    CC_LTS    = 4'h6,
    CC_LES    = 4'h7,
    CC_NOVF   = 4'h8,
    CC_NCARRY = 4'h9,
    CC_NZERO  = 4'hA,
    CC_GTU    = 4'hB,
    CC_POS    = 4'hC,
    CC_SATUR  = 4'hD,
    CC_GES    = 4'hE,
    CC_GTS    = 4'hF
  } cc_code_t;

  // One condition, written out for each code on its own.
  function automatic logic cc_eval(input cc_code_t code, input psw_flags_t f);
    logic r;
    case (code)
      CC_OVF:    r = f.ov;
      CC_CARRY:  r = f.cy;
      CC_ZERO:   r = f.z;
      CC_LEU:    r = f.cy | f.z;
      CC_NEG:    r = f.s;
      CC_ALWAYS: r = 1'b1;
      CC_LTS:    r = f.s ^ f.ov;
      CC_LES:    r = (f.s ^ f.ov) | f.z;
      CC_NOVF:   r = ~f.ov;
      CC_NCARRY: r = ~f.cy;
      CC_NZERO:  r = ~f.z;
      CC_GTU:    r = ~(f.cy | f.z);
      CC_POS:    r = ~f.s;
      CC_SATUR:  r = f.sat;
      CC_GES:    r = ~(f.s ^ f.ov);
      CC_GTS:    r = ~((f.s ^ f.ov) | f.z);
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cc_table.sv
module cc_table
  import ccu_pkg::*;
#(
  parameter int SEL_W = 4,
  localparam int NCODES = 1 << SEL_W,
  localparam int HALF = NCODES / 2
) (
  input  logic [SEL_W-1:0]  sel,
  input  psw_flags_t        flags,
  output logic [NCODES-1:0] hits,
  output logic              hit
);

  for (genvar i = 0; i < NCODES; i++) begin : g_code
    assign hits[i] = cc_eval(cc_code_t'(i), flags);
  end

  assign hit = hits[sel];

  always_comb begin
    if (!$isunknown(flags)) begin
      AST_ALWAYS_CODE: assert (hits[5] == 1'b1) else $error("always code false"); // R2
      AST_SAT_CODE: assert (hits[13] == flags.sat) else $error("sat code mismatch"); // R5
      for (int k = 0; k < HALF; k++) begin
        if (k != 5) begin
          AST_PAIR_INVERSE: assert (hits[k] != hits[k+HALF]) else $error("pair %0d not inverse", k); // R4
        end
      end
    end
  end

endmodule

// File: rtl/branch_target.sv
module branch_target #(
  parameter int XLEN = 32,
  parameter int DISP_W = 9,
  parameter int STEP = 2
) (
  input  logic              taken,
  input  logic [XLEN-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  output logic [XLEN-1:0]   disp_ext,
  output logic [XLEN-1:0]   target
);

  localparam int EXT_W = XLEN - DISP_W;

  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign target   = pc + (taken ? disp_ext : XLEN'(STEP));

  always_comb begin
    if (!$isunknown(disp)) begin
      AST_SIGN_FILL: assert (disp[DISP_W-1] ? (disp_ext[XLEN-1:DISP_W] == '1)
                                           : (disp_ext[XLEN-1:DISP_W] == '0))
        else $error("sign fill wrong"); // R9
    end
  end

endmodule

// File: rtl/setflag_word.sv
module setflag_word #(
  parameter int XLEN = 32
) (
  input  logic            hit,
  output logic [XLEN-1:0] word
);

  assign word = {{(XLEN-1){1'b0}}, hit};

endmodule

// File: rtl/cond_unit.sv
module cond_unit
  import ccu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int DISP_W = 9,
  parameter int SEL_W = 4,
  parameter int STEP = 2
) (
  input  logic [SEL_W-1:0]  cc_sel,
  input  logic              flag_ov,
  input  logic              flag_cy,
  input  logic              flag_z,
  input  logic              flag_s,
  input  logic              flag_sat,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [DISP_W-1:0] disp,
  output logic              cond_true,
  output logic [XLEN-1:0]   next_pc,
  output logic [XLEN-1:0]   flag_word
);

  localparam int NCODES = 1 << SEL_W;

  psw_flags_t        flags;
  logic [NCODES-1:0] all_hits;
  logic [XLEN-1:0]   disp_wide;

  assign flags = '{ov: flag_ov, cy: flag_cy, z: flag_z, s: flag_s, sat: flag_sat};

  cc_table #(.SEL_W(SEL_W)) u_table (
    .sel   (cc_sel),
    .flags (flags),
    .hits  (all_hits),
    .hit   (cond_true)
  );

  branch_target #(.XLEN(XLEN), .DISP_W(DISP_W), .STEP(STEP)) u_target (
    .taken    (cond_true),
    .pc       (cur_pc),
    .disp     (disp),
    .disp_ext (disp_wide),
    .target   (next_pc)
  );

  setflag_word #(.XLEN(XLEN)) u_word (
    .hit  (cond_true),
    .word (flag_word)
  );

  always_comb begin
    if (!$isunknown({cc_sel, flags, cur_pc, disp})) begin
      AST_TAKEN_TARGET: assert (!cond_true || (next_pc - cur_pc) == disp_wide)
        else $error("taken target wrong"); // R6
      AST_FALLTHROUGH: assert (cond_true || (next_pc - cur_pc) == XLEN'(STEP))
        else $error("fall-through wrong"); // R7
      AST_WORD_BOOL: assert (flag_word[XLEN-1:1] == '0 && flag_word[0] == cond_true)
        else $error("flag word not boolean"); // R8
    end
  end

endmodule

// File: tb/cond_unit_test.sv
module cond_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cc_sel = '0;
  logic        flag_ov = 1'b0, flag_cy = 1'b0, flag_z = 1'b0, flag_s = 1'b0, flag_sat = 1'b0;
  logic [31:0] cur_pc = '0;
  logic [8:0]  disp = '0;
  logic        cond_true;
  logic [31:0] next_pc;
  logic [31:0] flag_word;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cond_unit uut (
    .cc_sel(cc_sel), .flag_ov(flag_ov), .flag_cy(flag_cy), .flag_z(flag_z),
    .flag_s(flag_s), .flag_sat(flag_sat), .cur_pc(cur_pc), .disp(disp),
    .cond_true(cond_true), .next_pc(next_pc), .flag_word(flag_word)
  );

  // Reference: base test from low 3 bits, bit 3 inverts, code 13 is sat.
  function automatic bit ref_cond(input bit [3:0] c, input bit [4:0] f);
    bit ov, cy, z, s, sat, base;
    {ov, cy, z, s, sat} = f;
    if (c == 4'd13) return sat;
    unique case (c[2:0])
      3'd0: base = ov;
      3'd1: base = cy;
      3'd2: base = z;
      3'd3: base = cy || z;
      3'd4: base = s;
      3'd5: base = 1'b1;
      3'd6: base = (s != ov);
      default: base = (s != ov) || z;
    endcase
    return c[3] ? !base : base;
  endfunction

  function automatic bit [31:0] ref_pc(input bit t, input bit [31:0] pc, input bit [8:0] d);
    int signed off;
    off = t ? int'($signed(d)) : 2;
    return pc + 32'(off);
  endfunction

  task automatic check(input string req, input bit [31:0] act, input bit [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (sel=%0d flags=%b pc=%h disp=%h)",
               req, act, exp, cc_sel, {flag_ov, flag_cy, flag_z, flag_s, flag_sat}, cur_pc, disp);
    end
  endtask

  task automatic apply(input bit [3:0] c, input bit [4:0] f, input bit [31:0] pc, input bit [8:0] d);
    @(negedge clk);
    cc_sel = c;
    {flag_ov, flag_cy, flag_z, flag_s, flag_sat} = f;
    cur_pc = pc;
    disp = d;
    #1;
  endtask

  task automatic check_all(input string req);
    bit e;
    e = ref_cond(cc_sel, {flag_ov, flag_cy, flag_z, flag_s, flag_sat});
    check(req, 32'(cond_true), 32'(e));
    check({req, "/R8"}, flag_word, 32'(e));
    check(e ? "R6" : "R7", next_pc, ref_pc(e, cur_pc, disp));
  endtask

  initial begin
    bit [31:0] seed_v;
    seed_v = $urandom(32'h5EED_0C0D);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle inputs after reset: code 0, no flags -> false, pc+2.
    apply(4'd0, 5'b0, 32'h0, 9'h0);
    check("R1 reset", 32'(cond_true), 32'd0);
    check("R7 reset", next_pc, 32'd2);

    // Exhaustive: every code against every flag pattern.
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 32; f++) begin
        apply(4'(c), 5'(f), 32'h0000_1000, 9'h010);
        if (c == 5)       check_all("R2");
        else if (c == 13) check_all("R5");
        else if (c >= 8)  check_all("R4");
        else if (c >= 6)  check_all("R3");
        else              check_all("R1");
      end
    end

    // Directed displacement extremes (R9).
    apply(4'd5, 5'b0, 32'h0000_1000, 9'h100);
    check("R9 min disp", next_pc, 32'h0000_0F00);
    apply(4'd5, 5'b0, 32'h0000_1000, 9'h0FF);
    check("R9 max disp", next_pc, 32'h0000_10FF);
    apply(4'd5, 5'b0, 32'h0000_0004, 9'h1F8);
    check("R6 wrap down", next_pc, 32'hFFFF_FFFC);
    apply(4'd5, 5'b0, 32'hFFFF_FFF0, 9'h020);
    check("R6 wrap up", next_pc, 32'h0000_0010);
    apply(4'd13, 5'b0, 32'hFFFF_FFFF, 9'h100);
    check("R7 wrap", next_pc, 32'h0000_0001);
    apply(4'd7, 5'b00100, 32'h0000_2000, 9'h1FE);
    check("R3 z only", next_pc, 32'h0000_1FFE);

    // Random mix.
    for (int i = 0; i < 400; i++) begin
      apply(4'($urandom), 5'($urandom), $urandom, 9'($urandom));
      check_all("R1-mix");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail);
      $finish;
    end
  end

endmodule